// File: doc/BRIEF.md
# Framebuffer Pixel Access Register Window

This block lets a processor reach a 320 x 240 screen of 8-bit pixels through four 16-bit word registers, with no linear mapping of the frame. Software first loads a row pointer and a column pointer. It then reads or writes the pixel at that position through a data register. A write to a fourth register asks the display side for a full-screen refresh, and the block signals this on a one-cycle strobe. The pixel storage sits outside the block on a simple synchronous-read memory port. The block produces the linear pixel address, the write and read strobes, and the write byte, and it returns the read byte to the bus.

The bus is a single-cycle strobe interface. `bus_en` marks an access, `bus_wr` is 1 for a write and 0 for a read, and `bus_off` selects the register: 0 is the row pointer, 1 the column pointer, 2 the pixel data and 3 the refresh request. Read data appears on `bus_rdata` in the cycle after the read request. A separate combinational lookup turns a pixel value into red, green and blue levels for a scan-out path, using a fixed eight-colour table.

Top module: `fb_pixel_window`

## Requirements
- R1: After reset, the row and column pointers are 0, `bus_rdata` is 0 and `refresh_pulse` is 0.
- R2: A write at offset 0 (row) or offset 1 (column) stores all 16 bits of `bus_wdata`. A read at the same offset returns the stored value on `bus_rdata` in the cycle after the request. A pointer changes only on a write to its own offset.
- R3: A write at offset 2 with the position in range asserts `mem_we` in the same cycle as the request. It drives `mem_addr` = row x 320 + column and `mem_wdata` = `bus_wdata[7:0]`. The row and column pointers are unchanged.
- R4: A read at offset 2 with the position in range asserts `mem_re` in the same cycle at the same address. The byte the memory returns one cycle later appears on `bus_rdata`, zero-extended to 16 bits, in the cycle after the request.
- R5: A position is out of range when row >= 240 or column >= 320. An out-of-range pixel write asserts no `mem_we` and leaves every stored pixel unchanged. An out-of-range pixel read asserts no `mem_re` and returns 0.
- R6: A write at offset 3 makes `refresh_pulse` high for exactly the one cycle after the write. A read at offset 3 returns 0.
- R7: The palette maps index 0 to black (0,0,0). Indices 1, 2 and 3 give half level 127 on red, green and blue alone. Indices 4, 5 and 6 give full level 255 on red, green and blue alone. Index 7 gives white (255,255,255). The lookup is combinational.
- R8: Palette indices 8 to 255 map to black.
- R9: `bus_rdata` is 0 in every cycle that does not directly follow a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_off | input | 2 | Register select: 0 row, 1 column, 2 pixel, 3 refresh |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after a read |
| mem_addr | output | 17 | Linear pixel address row x 320 + column |
| mem_re | output | 1 | Pixel memory read strobe |
| mem_we | output | 1 | Pixel memory write strobe |
| mem_wdata | output | 8 | Pixel byte to store |
| mem_rdata | input | 8 | Pixel byte from memory, one cycle after `mem_re` |
| refresh_pulse | output | 1 | One-cycle refresh request |
| pal_index | input | 8 | Pixel value to look up |
| pal_red | output | 8 | Red level |
| pal_green | output | 8 | Green level |
| pal_blue | output | 8 | Blue level |

## Verification
The pixel path is tested at the origin, at the far corner (239, 319) and at an interior point. These cases separate a correct row x 320 + column address from a swapped or shifted one. Writes whose upper data byte is non-zero show whether the low byte is stored and whether the read is zero-extended. An out-of-range write at column 327 of row 5 would alias onto row 6, column 7 if it were not blocked, so a read of that pixel afterwards shows whether the range check guards the store. Idle cycles, back-to-back accesses and a sweep of all 256 palette indices separate the held read-data behaviour, the single-cycle refresh strobe and the colour table from plausible wrong variants.

// File: rtl/fb_pkg.sv
package fb_pkg;

   // Register select codes on the bus offset field.
   typedef enum logic [1:0] {
      FB_OFF_ROW  = 2'd0,
      FB_OFF_COL  = 2'd1,
      FB_OFF_PIX  = 2'd2,
      FB_OFF_REFR = 2'd3
   } fb_off_e;

   // What drives the read data in the cycle after a request.
   typedef enum logic [1:0] {
      FB_RK_NONE = 2'd0,
      FB_RK_HOLD = 2'd1,
      FB_RK_PIX  = 2'd2
   } fb_rdkind_e;

endpackage

// File: rtl/fb_pos_regs.sv
module fb_pos_regs #(
   parameter int FB_W   = 320,
   parameter int FB_H   = 240,
   parameter int REG_W  = 16,
   parameter int ADDR_W = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_row_i,
   input  logic              wr_col_i,
   input  logic [REG_W-1:0]  wdata_i,
   output logic [REG_W-1:0]  row_o,
   output logic [REG_W-1:0]  col_o,
   output logic              in_range_o,
   output logic [ADDR_W-1:0] addr_o
);

   localparam logic [REG_W-1:0] W_L    = REG_W'(FB_W);
   localparam logic [REG_W-1:0] H_L    = REG_W'(FB_H);
   localparam bit               W_POW2 = ((FB_W & (FB_W - 1)) == 0);
   localparam int               W_SH   = (FB_W > 1) ? $clog2(FB_W) : 1;

   logic [REG_W-1:0] row_q;
   logic [REG_W-1:0] col_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q <= '0;
         col_q <= '0;
      end else begin
         if (wr_row_i) row_q <= wdata_i;
         if (wr_col_i) col_q <= wdata_i;
      end
   end

   assign row_o      = row_q;
   assign col_o      = col_q;
   assign in_range_o = (row_q < H_L) && (col_q < W_L);

   // Linear address: a shift when the width is a power of two, else a multiply-add.
   generate
      if (W_POW2) begin : g_addr_shift
         logic [2*REG_W-1:0] lin;
         always_comb begin
            lin = ({{REG_W{1'b0}}, row_q} << W_SH) | {{REG_W{1'b0}}, col_q};
         end
         assign addr_o = lin[ADDR_W-1:0];
      end else begin : g_addr_mul
         logic [2*REG_W-1:0] lin;
         always_comb begin
            lin = ({{REG_W{1'b0}}, row_q} * {{REG_W{1'b0}}, W_L})
                  + {{REG_W{1'b0}}, col_q};
         end
         assign addr_o = lin[ADDR_W-1:0];
      end
   endgenerate

   // R2: pointers only move on their own write strobe.
   p_row_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_row_i |=> $stable(row_q));
   p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_col_i |=> $stable(col_q));

endmodule

// File: rtl/fb_pixel_port.sv
module fb_pixel_port
   import fb_pkg::*;
#(
   parameter int REG_W  = 16,
   parameter int PIX_W  = 8,
   parameter int ADDR_W = 17,
   parameter int NPIX   = 76800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [1:0]        bus_off,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   input  logic [REG_W-1:0]  row_i,
   input  logic [REG_W-1:0]  col_i,
   input  logic              in_range_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_row_o,
   output logic              wr_col_o,
   output logic              mem_re,
   output logic              mem_we,
   output logic [PIX_W-1:0]  mem_wdata,
   input  logic [PIX_W-1:0]  mem_rdata,
   output logic              refresh_pulse
);

   localparam logic [ADDR_W:0] NPIX_L = (ADDR_W+1)'(NPIX);

   fb_off_e    off;
   logic       acc_wr;
   logic       acc_rd;
   fb_rdkind_e kind_d, kind_q;
   logic [REG_W-1:0] hold_d, hold_q;
   logic       refr_q;

   assign off    = fb_off_e'(bus_off);
   assign acc_wr = bus_en && bus_wr;
   assign acc_rd = bus_en && !bus_wr;

   // Write decode.
   assign wr_row_o  = acc_wr && (off == FB_OFF_ROW);
   assign wr_col_o  = acc_wr && (off == FB_OFF_COL);
   assign mem_we    = acc_wr && (off == FB_OFF_PIX) && in_range_i;
   assign mem_re    = acc_rd && (off == FB_OFF_PIX) && in_range_i;
   assign mem_wdata = bus_wdata[PIX_W-1:0];

   // Read steering for the following cycle.
   always_comb begin
      kind_d = FB_RK_NONE;
      hold_d = '0;
      if (acc_rd) begin
         unique case (off)
            FB_OFF_ROW: begin
               kind_d = FB_RK_HOLD;
               hold_d = row_i;
            end
            FB_OFF_COL: begin
               kind_d = FB_RK_HOLD;
               hold_d = col_i;
            end
            FB_OFF_PIX:  kind_d = in_range_i ? FB_RK_PIX : FB_RK_NONE;
            FB_OFF_REFR: kind_d = FB_RK_NONE;
            default:     kind_d = FB_RK_NONE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_q <= FB_RK_NONE;
         hold_q <= '0;
         refr_q <= 1'b0;
      end else begin
         kind_q <= kind_d;
         hold_q <= hold_d;
         refr_q <= acc_wr && (off == FB_OFF_REFR);
      end
   end

   always_comb begin
      unique case (kind_q)
         FB_RK_HOLD: bus_rdata = hold_q;
         FB_RK_PIX:  bus_rdata = {{(REG_W-PIX_W){1'b0}}, mem_rdata};
         default:    bus_rdata = '0;
      endcase
   end

   assign refresh_pulse = refr_q;

   // R5: a memory write never leaves the frame.
   p_we_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> ({1'b0, addr_i} < NPIX_L));
   // R6: the strobe only follows a refresh write.
   p_refresh_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
      refresh_pulse |-> $past(bus_en && bus_wr && (bus_off == 2'd3)));
   // R4: pixel reads come back zero-extended.
   p_pix_zext_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mem_re) |-> (bus_rdata[REG_W-1:PIX_W] == '0));
   // R9: no read request, no read data.
   p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!(bus_en && !bus_wr)) |-> (bus_rdata == '0));

endmodule

// File: rtl/fb_palette.sv
module fb_palette #(
   parameter int IDX_W    = 8,
   parameter int COL_W    = 8,
   parameter int HALF_LVL = 127,
   parameter int FULL_LVL = 255
) (
   input  logic [IDX_W-1:0] idx_i,
   output logic [COL_W-1:0] red_o,
   output logic [COL_W-1:0] green_o,
   output logic [COL_W-1:0] blue_o
);

   localparam logic [COL_W-1:0] HALF_L = COL_W'(HALF_LVL);
   localparam logic [COL_W-1:0] FULL_L = COL_W'(FULL_LVL);
   localparam int NCH = 3;

   logic [COL_W-1:0] chan [NCH];

   // Channel ch: half at index 1+ch, full at 4+ch, full at white (7).
   generate
      for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
         always_comb begin
            if (idx_i == IDX_W'(1 + ch))      chan[ch] = HALF_L;
            else if (idx_i == IDX_W'(4 + ch)) chan[ch] = FULL_L;
            else if (idx_i == IDX_W'(7))      chan[ch] = FULL_L;
            else                              chan[ch] = '0;
         end
      end
   endgenerate

   assign red_o   = chan[0];
   assign green_o = chan[1];
   assign blue_o  = chan[2];

endmodule

// File: rtl/fb_pixel_window.sv
module fb_pixel_window
   import fb_pkg::*;
#(
   parameter int FB_W     = 320,
   parameter int FB_H     = 240,
   parameter int REG_W    = 16,
   parameter int PIX_W    = 8,
   parameter int COL_W    = 8,
   parameter int HALF_LVL = 127,
   parameter int FULL_LVL = 255,
   localparam int NPIX    = FB_W * FB_H,
   localparam int ADDR_W  = $clog2(NPIX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_en,
   input  logic              bus_wr,
   input  logic [1:0]        bus_off,
   input  logic [REG_W-1:0]  bus_wdata,
   output logic [REG_W-1:0]  bus_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_re,
   output logic              mem_we,
   output logic [PIX_W-1:0]  mem_wdata,
   input  logic [PIX_W-1:0]  mem_rdata,
   output logic              refresh_pulse,
   input  logic [PIX_W-1:0]  pal_index,
   output logic [COL_W-1:0]  pal_red,
   output logic [COL_W-1:0]  pal_green,
   output logic [COL_W-1:0]  pal_blue
);

   // Elaboration-time parameter checks.
   generate
      if (PIX_W >= REG_W) begin : g_bad_pix
         $error("PIX_W must be narrower than REG_W");
      end
      if (FB_W < 2 || FB_H < 1) begin : g_bad_dim
         $error("frame dimensions too small");
      end
      if (FB_W >= (1 << REG_W) || FB_H >= (1 << REG_W)) begin : g_bad_ptr
         $error("pointer registers too narrow for the frame");
      end
      if (ADDR_W > 2 * REG_W) begin : g_bad_addr
         $error("address wider than pointer product");
      end
      if (HALF_LVL >= (1 << COL_W) || FULL_LVL >= (1 << COL_W)) begin : g_bad_lvl
         $error("colour level exceeds COL_W");
      end
   endgenerate

   logic [REG_W-1:0]  row;
   logic [REG_W-1:0]  col;
   logic              in_range;
   logic [ADDR_W-1:0] addr;
   logic              wr_row;
   logic              wr_col;

   fb_pos_regs #(
      .FB_W   (FB_W),
      .FB_H   (FB_H),
      .REG_W  (REG_W),
      .ADDR_W (ADDR_W)
   ) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_row_i   (wr_row),
      .wr_col_i   (wr_col),
      .wdata_i    (bus_wdata),
      .row_o      (row),
      .col_o      (col),
      .in_range_o (in_range),
      .addr_o     (addr)
   );

   fb_pixel_port #(
      .REG_W  (REG_W),
      .PIX_W  (PIX_W),
      .ADDR_W (ADDR_W),
      .NPIX   (NPIX)
   ) u_port (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_en        (bus_en),
      .bus_wr        (bus_wr),
      .bus_off       (bus_off),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .row_i         (row),
      .col_i         (col),
      .in_range_i    (in_range),
      .addr_i        (addr),
      .wr_row_o      (wr_row),
      .wr_col_o      (wr_col),
      .mem_re        (mem_re),
      .mem_we        (mem_we),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata),
      .refresh_pulse (refresh_pulse)
   );

   fb_palette #(
      .IDX_W    (PIX_W),
      .COL_W    (COL_W),
      .HALF_LVL (HALF_LVL),
      .FULL_LVL (FULL_LVL)
   ) u_pal (
      .idx_i   (pal_index),
      .red_o   (pal_red),
      .green_o (pal_green),
      .blue_o  (pal_blue)
   );

   assign mem_addr = addr;

endmodule

// File: tb/tb_fb_pixel_window.sv
module tb_fb_pixel_window;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0;
   logic        bus_wr = 1'b0;
   logic [1:0]  bus_off = 2'd0;
   logic [15:0] bus_wdata = 16'd0;
   logic [15:0] bus_rdata;
   logic [16:0] mem_addr;
   logic        mem_re;
   logic        mem_we;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = 8'd0;
   logic        refresh_pulse;
   logic [7:0]  pal_index = 8'd0;
   logic [7:0]  pal_red, pal_green, pal_blue;

   int checks = 0;
   int errors = 0;

   // Behavioural reference state.
   int    m_row = 0;
   int    m_col = 0;
   int    exp_rdata = 0;
   int    exp_ref = 0;
   string exp_req = "R1";
   int    exp_px [int];
   logic [7:0] ram [int];

   always #10 clk = ~clk;

   fb_pixel_window dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_en        (bus_en),
      .bus_wr        (bus_wr),
      .bus_off       (bus_off),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .mem_addr      (mem_addr),
      .mem_re        (mem_re),
      .mem_we        (mem_we),
      .mem_wdata     (mem_wdata),
      .mem_rdata     (mem_rdata),
      .refresh_pulse (refresh_pulse),
      .pal_index     (pal_index),
      .pal_red       (pal_red),
      .pal_green     (pal_green),
      .pal_blue      (pal_blue)
   );

   // Synchronous-read pixel memory.
   always @(posedge clk) begin
      if (mem_we) ram[int'(mem_addr)] = mem_wdata;
      if (mem_re) mem_rdata <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'd0;
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One bus cycle: check last cycle's registered results, drive, check strobes, advance model.
   task automatic step(input bit en, input bit wr, input int off, input int data);
      bit inr;
      bit e_we;
      bit e_re;
      int a;
      @(negedge clk);
      chk(exp_req, "bus_rdata", int'(bus_rdata), exp_rdata);
      chk("R6", "refresh_pulse", int'(refresh_pulse), exp_ref);
      bus_en    = en;
      bus_wr    = wr;
      bus_off   = off[1:0];
      bus_wdata = data[15:0];
      #1;
      inr  = (m_row < 240) && (m_col < 320);
      a    = m_row * 320 + m_col;
      e_we = en && wr && (off == 2) && inr;
      e_re = en && !wr && (off == 2) && inr;
      chk("R5", "mem_we", int'(mem_we), int'(e_we));
      chk("R5", "mem_re", int'(mem_re), int'(e_re));
      if (e_we || e_re) chk("R3", "mem_addr", int'(mem_addr), a);
      if (e_we) chk("R3", "mem_wdata", int'(mem_wdata), data & 255);
      exp_ref   = (en && wr && off == 3) ? 1 : 0;
      exp_rdata = 0;
      exp_req   = "R9";
      if (en && !wr) begin
         case (off)
            0: begin exp_rdata = m_row; exp_req = "R2"; end
            1: begin exp_rdata = m_col; exp_req = "R2"; end
            2: begin
               exp_req   = inr ? "R4" : "R5";
               exp_rdata = (inr && exp_px.exists(a)) ? exp_px[a] : 0;
            end
            default: begin exp_rdata = 0; exp_req = "R6"; end
         endcase
      end
      if (en && wr) begin
         case (off)
            0: m_row = data & 16'hFFFF;
            1: m_col = data & 16'hFFFF;
            2: if (inr) exp_px[a] = data & 255;
            default: ;
         endcase
      end
   endtask

   task automatic set_pos(input int r, input int c);
      step(1, 1, 0, r);
      step(1, 1, 1, c);
   endtask

   function automatic int pal_exp(input int i);
      case (i)
         0: return 0;
         1: return 32'h7F0000;
         2: return 32'h007F00;
         3: return 32'h00007F;
         4: return 32'hFF0000;
         5: return 32'h00FF00;
         6: return 32'h0000FF;
         7: return 32'hFFFFFF;
         default: return 0;
      endcase
   endfunction

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: reset values
      step(0, 0, 0, 0);
      step(1, 0, 0, 0);
      step(1, 0, 1, 0);
      // R2: pointer write and readback, full 16 bits
      set_pos(5, 7);
      step(1, 0, 0, 0);
      step(1, 0, 1, 0);
      step(1, 1, 0, 16'hBEEF);
      step(1, 0, 0, 0);
      set_pos(5, 7);
      // R3 and R4: interior pixel, upper data byte discarded
      step(1, 1, 2, 16'hABCD);
      step(1, 0, 2, 0);
      step(1, 0, 0, 0);
      step(1, 0, 1, 0);
      // Origin and far corner
      set_pos(0, 0);
      step(1, 1, 2, 16'h1234);
      set_pos(239, 319);
      step(1, 1, 2, 16'hFF5A);
      step(1, 0, 2, 0);
      set_pos(0, 0);
      step(1, 0, 2, 0);
      step(0, 0, 0, 0);
      // R5: alias target first, then blocked write that would land on it
      set_pos(6, 7);
      step(1, 1, 2, 16'h0011);
      set_pos(5, 327);
      step(1, 1, 2, 16'h0099);
      step(1, 0, 2, 0);
      set_pos(6, 7);
      step(1, 0, 2, 0);
      set_pos(240, 0);
      step(1, 1, 2, 16'h0055);
      step(1, 0, 2, 0);
      set_pos(16'hFFFF, 16'hFFFF);
      step(1, 0, 2, 0);
      step(1, 1, 2, 16'h0077);
      set_pos(239, 319);
      step(1, 0, 2, 0);
      // R6: refresh strobe, back-to-back, and read of offset 3
      step(1, 1, 3, 16'hFFFF);
      step(0, 0, 0, 0);
      step(1, 1, 3, 0);
      step(1, 1, 3, 0);
      step(1, 0, 3, 0);
      // R9: idle after reads
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      step(0, 0, 0, 0);
      // R7 and R8: palette sweep
      @(negedge clk);
      for (int i = 0; i < 256; i++) begin
         pal_index = i[7:0];
         #1;
         chk(i < 8 ? "R7" : "R8", "palette rgb",
             int'({pal_red, pal_green, pal_blue}), pal_exp(i));
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule